// File: doc/BRIEF.md
# SPI Flash Status-Register Guard

This block is the command and status front end of a serial NOR flash slave. It watches a mode-0 SPI link (chip select active low, clock, serial data in, serial data out) and handles four commands. Write-enable and write-disable set and clear a write-enable latch. Read-status streams back the status byte. Write-status updates a protect-lock bit and a quad-enable bit. All SPI pins and the active-low write-protect pin are brought into the system clock domain through synchronizers. SCK edges are then found by comparing successive samples, so the system clock must run several times faster than SCK.

Write-status is gated in two ways. First, the write-enable latch must be set. Second, the block looks at the write-protect pin at the moment the opcode is decoded. If the pin is low and the protect-lock bit is set, the block is in hardware-protected mode and the command is refused. Every other combination is software-protected mode, and the write goes ahead. A refused command collects nothing and changes nothing. The parameter `SR_BYTES` sets how many data bytes an accepted write-status takes: 1 (the default) or 2.

The controller is a four-state machine:
- `ST_OPCODE` waits for the first byte after chip select falls.
- It moves to `ST_STATUS_OUT` on read-status.
- It moves to `ST_COLLECT` on an accepted write-status.
- It moves to `ST_SKIP` on a refused write-status, on write-enable or write-disable, and on any other opcode.
- From every state it returns to `ST_OPCODE` when chip select rises. If that rise leaves `ST_COLLECT` with the right byte count, it commits the status write.

Top module: `flash_sr_guard`

## Requirements
- R1: Opcode 0x06, shifted in MSB first on rising SCK, sets the write-enable latch. The latch reads back as status bit 1.
- R2: Opcode 0x04 clears the write-enable latch.
- R3: Opcode 0x05 makes MISO carry the status byte, MSB first, changing only on falling SCK. The byte is repeated for as long as chip select stays low. Layout: bit 7 = protect-lock, bit 6 = quad-enable (single-byte variant only, otherwise 0), bit 1 = write-enable latch, all other bits 0.
- R4: Opcode 0x01 with the write-enable latch clear is refused: no status bit changes.
- R5: Opcode 0x01 is refused when the synchronized write-protect pin is low and protect-lock is 1. With any of the other three combinations (and the latch set), the write is accepted.
- R6: An accepted write commits only when chip select rises after exactly `SR_BYTES` whole data bytes. Fewer bytes, more bytes, or a partial byte leave every status bit unchanged, including the latch.
- R7: On commit, protect-lock takes bit 7 of the first data byte. Quad-enable takes bit 6 of the first byte when `SR_BYTES`=1, or bit 1 of the second byte when `SR_BYTES`=2. The write-enable latch is cleared.
- R8: After reset, the status byte is 0x00, MISO is low, and the write-protect level counts as high until the pin has been synchronized.
- R9: Any other opcode is ignored, together with every byte that follows it, until chip select rises.
- R10: The write-protect level is sampled when the write-status opcode is decoded. Changes to the pin during the data bytes have no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial status data out of the block |

## Verification
A wrong latch or lock value shows up at MISO in the very next read-status transaction, since every status bit is streamed there. A wrong decision in the protection gate, or a commit at the wrong moment, changes the byte read back straight after the write. The bench therefore sweeps every combination of latch, lock and write-protect level across several data bytes, and follows each write with a read. A fault in the output shifter shows within one SCK half period: MISO changes in the rising half of the clock, or the byte repeated during one read is not the same byte.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    typedef enum logic [1:0] {
        ST_OPCODE,
        ST_STATUS_OUT,
        ST_COLLECT,
        ST_SKIP
    } sr_state_e;

endpackage

// File: rtl/flash_sr_sync.sv
module flash_sr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/flash_sr_shifter.sv
module flash_sr_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ld_en,
    input  logic [BW-1:0] ld_val,
    output logic [BW-1:0] rx_byte,
    output logic          rx_vld,
    output logic          at_bound,
    output logic          miso
);

    localparam int CW = $clog2(BW);

    logic          sck_d;
    logic          sck_rise;
    logic          sck_fall;
    logic [CW-1:0] bit_cnt;
    logic [BW-2:0] shreg;
    logic [BW-1:0] tx_q;
    logic          miso_q;

    assign sck_rise = cs_act &  sck_s & ~sck_d;
    assign sck_fall = cs_act & ~sck_s &  sck_d;
    assign at_bound = (bit_cnt == '0);
    assign miso     = miso_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            rx_byte <= '0;
            rx_vld  <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            rx_vld <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[BW-3:0], mosi_s};
                if (bit_cnt == CW'(BW-1)) begin
                    bit_cnt <= '0;
                    rx_byte <= {shreg, mosi_s};
                    rx_vld  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (!cs_act) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (ld_en) begin
            tx_q <= ld_val;
        end else if (sck_fall) begin
            miso_q <= tx_q[BW-1];
            tx_q   <= {tx_q[BW-2:0], tx_q[BW-1]};
        end
    end

    // R3
    miso_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sck_fall) |=> $stable(miso_q));

endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
    import flash_sr_pkg::*;
#(
    parameter int SR_BYTES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_act,
    input  logic       cs_rise,
    input  logic [7:0] rx_byte,
    input  logic       rx_vld,
    input  logic       at_bound,
    input  logic       wp_s,
    output logic       ld_en,
    output logic [7:0] ld_val
);

    localparam int CNTW = $clog2(SR_BYTES + 2);

    sr_state_e       state_q, state_d;
    logic            wel_q, srwd_q, qe_q;
    logic [CNTW-1:0] cnt_q;
    logic [7:0]      buf0_q, buf1_q;
    logic            decode;
    logic            hw_locked;
    logic            commit;
    logic [7:0]      status;

    assign decode    = (state_q == ST_OPCODE) && rx_vld;
    assign hw_locked = !wp_s && srwd_q;
    assign commit    = cs_rise && (state_q == ST_COLLECT) &&
                       (cnt_q == CNTW'(SR_BYTES)) && at_bound;
    assign status    = {srwd_q, (SR_BYTES == 1) ? qe_q : 1'b0, 4'b0000, wel_q, 1'b0};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: begin
                if (rx_vld) begin
                    case (rx_byte)
                        OP_RDSR: state_d = ST_STATUS_OUT;
                        OP_WRSR: state_d = (wel_q && !hw_locked) ? ST_COLLECT : ST_SKIP;
                        default: state_d = ST_SKIP;
                    endcase
                end
            end
            ST_STATUS_OUT: state_d = ST_STATUS_OUT;
            ST_COLLECT:    state_d = ST_COLLECT;
            ST_SKIP:       state_d = ST_SKIP;
        endcase
        if (!cs_act) state_d = ST_OPCODE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            srwd_q <= 1'b0;
            qe_q   <= 1'b0;
            cnt_q  <= '0;
            buf0_q <= '0;
            buf1_q <= '0;
        end else begin
            if (commit) begin
                srwd_q <= buf0_q[7];
                qe_q   <= (SR_BYTES == 1) ? buf0_q[6] : buf1_q[1];
                wel_q  <= 1'b0;
            end
            if (decode) begin
                if (rx_byte == OP_WREN) wel_q <= 1'b1;
                if (rx_byte == OP_WRDI) wel_q <= 1'b0;
                if (rx_byte == OP_WRSR) cnt_q <= '0;
            end
            if (state_q == ST_COLLECT && rx_vld) begin
                if (cnt_q == CNTW'(0)) buf0_q <= rx_byte;
                if (cnt_q == CNTW'(1)) buf1_q <= rx_byte;
                if (cnt_q <= CNTW'(SR_BYTES)) cnt_q <= cnt_q + CNTW'(1);
            end
        end
    end

    assign ld_en  = rx_vld && ((state_q == ST_OPCODE && rx_byte == OP_RDSR) ||
                               state_q == ST_STATUS_OUT);
    assign ld_val = status;

    // R4
    collect_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COLLECT) |-> $past(wel_q));

    // R5
    collect_not_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_COLLECT) |-> !(!$past(wp_s) && $past(srwd_q)));

    // R7
    wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel_q);

    // R6
    srwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(srwd_q));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(SR_BYTES + 1));

endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard #(
    parameter int SR_BYTES    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);

    localparam int BW = 8;

    logic [3:0]    pins_s;
    logic          wp_s, cs_s, sck_s, mosi_s;
    logic          cs_d;
    logic          cs_act;
    logic          cs_rise;
    logic [BW-1:0] rx_byte;
    logic          rx_vld;
    logic          at_bound;
    logic          ld_en;
    logic [BW-1:0] ld_val;

    flash_sr_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wp_n, cs_n, sck, mosi}),
        .q     (pins_s)
    );

    assign {wp_s, cs_s, sck_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_d <= 1'b1;
        else        cs_d <= cs_s;
    end

    assign cs_act  = !cs_s;
    assign cs_rise = cs_s && !cs_d;

    flash_sr_shifter #(
        .BW (BW)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_s    (sck_s),
        .mosi_s   (mosi_s),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .rx_byte  (rx_byte),
        .rx_vld   (rx_vld),
        .at_bound (at_bound),
        .miso     (miso)
    );

    flash_sr_ctrl #(
        .SR_BYTES (SR_BYTES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .cs_rise  (cs_rise),
        .rx_byte  (rx_byte),
        .rx_vld   (rx_vld),
        .at_bound (at_bound),
        .wp_s     (wp_s),
        .ld_en    (ld_en),
        .ld_val   (ld_val)
    );

    // R8
    reset_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso);

endmodule

// File: tb/flash_sr_guard_tb.sv
`timescale 1ns/1ps
module flash_sr_guard_tb;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    logic m_wel, m_srwd, m_qe, m_wp;
    logic [7:0] rx, got;

    always #2.5 clk = ~clk;

    flash_sr_guard u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .mosi  (mosi),
        .wp_n  (wp_n),
        .miso  (miso)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_srwd, m_qe, 4'b0000, m_wel, 1'b0};
    endfunction

    task automatic spi_bits(input int n, input logic [7:0] tx, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            tick(HALF);
            r[i] = miso;
            sck = 1'b1;
            tick(HALF);
            if (miso !== r[i]) begin
                compared++;
                mismatched++;
                $display("FAIL R3: miso moved in high phase, actual %0b expected %0b", miso, r[i]);
            end
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_high();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [7:0] d;
        cs_low();
        spi_bits(8, 8'h05, d);
        spi_bits(8, 8'h00, s);
        cs_high();
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_low();
        spi_bits(8, op, d);
        cs_high();
        if (op == 8'h06) m_wel = 1'b1;
        if (op == 8'h04) m_wel = 1'b0;
    endtask

    task automatic write_status(input logic [7:0] v);
        logic [7:0] d;
        logic ok;
        ok = m_wel && !(!m_wp && m_srwd);
        cs_low();
        spi_bits(8, 8'h01, d);
        spi_bits(8, v, d);
        cs_high();
        if (ok) begin
            m_srwd = v[7];
            m_qe   = v[6];
            m_wel  = 1'b0;
        end
    endtask

    task automatic set_wp(input logic v);
        wp_n = v;
        m_wp = v;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        m_wel = 0; m_srwd = 0; m_qe = 0; m_wp = 1;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        // R8 reset state
        check("R8 miso", {7'b0, miso}, 8'h00);
        read_status(got);
        check("R8 status", got, 8'h00);

        // R1 / R2
        cmd1(8'h06);
        read_status(got);
        check("R1 wren", got, exp_status());
        cmd1(8'h04);
        read_status(got);
        check("R2 wrdi", got, exp_status());

        // R3 repeat while CS low
        cmd1(8'h06);
        cs_low();
        spi_bits(8, 8'h05, d);
        for (int k = 0; k < 3; k++) begin
            spi_bits(8, 8'h00, got);
            check("R3 repeat", got, exp_status());
        end
        cs_high();

        // R9 unknown opcode swallows following bytes
        cmd1(8'h04);
        cs_low();
        spi_bits(8, 8'h03, d);
        spi_bits(8, 8'h06, d);
        cs_high();
        read_status(got);
        check("R9 ignored", got, exp_status());

        // R6 no data byte
        cmd1(8'h06);
        cs_low(); spi_bits(8, 8'h01, d); cs_high();
        read_status(got);
        check("R6 zero bytes", got, exp_status());
        // R6 two bytes
        cs_low(); spi_bits(8, 8'h01, d); spi_bits(8, 8'hC0, d); spi_bits(8, 8'hC0, d); cs_high();
        read_status(got);
        check("R6 extra byte", got, exp_status());
        // R6 partial byte
        cs_low(); spi_bits(8, 8'h01, d); spi_bits(8, 8'hC0, d); spi_bits(3, 8'hE0, d); cs_high();
        read_status(got);
        check("R6 partial", got, exp_status());

        // R4, R5, R7 sweep
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int v = 0; v < 256; v += 51) begin
                        set_wp(1'b1);
                        cmd1(8'h06);
                        write_status({s[0], 7'b0});
                        if (e == 0) cmd1(8'h04); else cmd1(8'h06);
                        set_wp(w[0]);
                        write_status(v[7:0]);
                        read_status(got);
                        if (e == 0)             check("R4 no latch", got, exp_status());
                        else if (s == 1 && w == 0) check("R5 hw locked", got, exp_status());
                        else                    check("R7 commit", got, exp_status());
                    end
                end
            end
        end

        // R10 wp dropped after decode: accepted
        set_wp(1'b1);
        cmd1(8'h06);
        write_status(8'h80);
        cmd1(8'h06);
        cs_low(); spi_bits(8, 8'h01, d);
        set_wp(1'b0);
        spi_bits(8, 8'h40, d);
        cs_high();
        m_srwd = 0; m_qe = 1; m_wel = 0;
        read_status(got);
        check("R10 late low", got, exp_status());
        // R10 wp low at decode with lock set, raised later: refused
        set_wp(1'b1);
        cmd1(8'h06);
        write_status(8'h80);
        cmd1(8'h06);
        set_wp(1'b0);
        cs_low(); spi_bits(8, 8'h01, d);
        set_wp(1'b1);
        spi_bits(8, 8'h00, d);
        cs_high();
        read_status(got);
        check("R10 late high", got, exp_status());

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule